// File: doc/BRIEF.md
# External Bus Turnaround Idle Sequencer

This block runs single read and write cycles on an external parallel bus. Each cycle addresses one memory area, identified by an area number given with the request. A normal cycle lasts three bus states: T1 (address set up), T2 and T3 (data phase). The sequencer keeps track of the direction and area of the cycle that is just completing. When a new request follows it back-to-back and the data bus would have to change driver, the sequencer inserts one idle state, TI, in front of the new cycle. This covers a slow device that is still releasing the bus after a read, and a write that follows a read.

The two idle cases are enabled separately. The first case is a read after a read from a different area. It needs its own enable bit and the advanced operating mode. The second case is a write directly after a read, and it has a separate enable bit. A request is taken only when the bus is free or in the last state (T3) of the current cycle. Any state in which the bus is free counts as a turnaround. So a request taken while the bus is free never gets an idle state.

Top module: `xbus_idle_seq`

## Requirements
- R1: An access with no inserted idle state takes exactly three states after acceptance, T1 then T2 then T3. `bus_ack` is high only during T3.
- R2: For a read, `bus_rd` is high in T2 and T3. For a write, `bus_wr` is high in T2 only and `bus_oe` is high in T2 and T3. All three are low in every other state.
- R3: A read accepted in the T3 state of a read to a different area gets exactly one TI state before its T1, provided `cfg_rr_gap` is 1 and `mode_adv` is 1.
- R4: A read accepted in the T3 state of a read to the same area gets no TI.
- R5: A read after a read from a different area gets no TI when `cfg_rr_gap` is 0 or `mode_adv` is 0.
- R6: A write accepted in the T3 state of a read gets exactly one TI when `cfg_wr_gap` is 1, and none when it is 0. Neither the area nor `mode_adv` affects this.
- R7: No access accepted in the T3 state of a write gets a TI.
- R8: During TI, `bus_rd`, `bus_wr`, `bus_oe` and `bus_ack` are low, and `bus_addr` already carries the new access's address.
- R9: A request accepted while the bus is free, including the first one after reset, never gets a TI.
- R10: While `rst` is high and in the cycle after it falls with no request, `bus_state` shows free and all strobes and `bus_ack` are low.
- R11: `bus_state` encodes the states as free=0, TI=1, T1=2, T2=3, T3=4.
- R12: `req_valid` is ignored while `bus_state` is TI, T1 or T2. The running access, its address and its timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when the bus is free or in T3 |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_area | input | AREA_W | Area number of the access |
| cfg_rr_gap | input | 1 | Enable idle state between reads of different areas |
| cfg_wr_gap | input | 1 | Enable idle state for a write after a read |
| mode_adv | input | 1 | Advanced operating mode; required for the read-read idle |
| bus_addr | output | ADDR_W | Address bus |
| bus_rd | output | 1 | Read strobe (active high) |
| bus_wr | output | 1 | Write strobe (active high) |
| bus_oe | output | 1 | Data-bus output enable |
| bus_state | output | 3 | Current bus state code |
| bus_ack | output | 1 | High in the final state of an access |

## Verification
Two things can happen in the same cycle: one access completes in T3, and the next request is accepted and judged for a gap against that completing access. The bench provokes this by presenting the second request exactly in the observed T3 state. It compares that case with the same pair issued one free state later, where no gap may appear. It sweeps every combination of both directions, same or different area, both enable bits and the mode. For each combination it predicts the whole state, strobe, address and acknowledge sequence arithmetically and compares it state by state.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    BS_FREE = 3'd0,
    BS_TI   = 3'd1,
    BS_T1   = 3'd2,
    BS_T2   = 3'd3,
    BS_T3   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/xbus_gap_decider.sv
module xbus_gap_decider #(
  parameter int AREA_W = 3
) (
  input  logic              prev_valid,
  input  logic              prev_write,
  input  logic [AREA_W-1:0] prev_area,
  input  logic              next_write,
  input  logic [AREA_W-1:0] next_area,
  input  logic              rr_en,
  input  logic              wr_en,
  input  logic              adv_mode,
  output logic              gap
);
  logic area_diff;
  logic rr_case;
  logic wr_case;

  always_comb begin
    area_diff = (next_area != prev_area);
    // read following a read from another area
    rr_case = !prev_write && !next_write && area_diff && rr_en && adv_mode;
    // write directly after a read
    wr_case = !prev_write && next_write && wr_en;
    gap = prev_valid && (rr_case || wr_case);
  end
endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic              gap,
  output bus_st_e           state_q,
  output bus_st_e           state_d,
  output logic              hist_valid,
  output logic              cur_write_q,
  output logic [AREA_W-1:0] cur_area_q,
  output logic [ADDR_W-1:0] addr_d,
  output logic              write_d
);
  logic              accept;
  logic [ADDR_W-1:0] cur_addr_q;

  // history is only meaningful while the current access completes
  assign hist_valid = (state_q == BS_T3);

  always_comb begin
    accept  = req_valid && (state_q == BS_FREE || state_q == BS_T3);
    state_d = state_q;
    unique case (state_q)
      BS_FREE, BS_T3: state_d = accept ? (gap ? BS_TI : BS_T1) : BS_FREE;
      BS_TI:          state_d = BS_T1;
      BS_T1:          state_d = BS_T2;
      BS_T2:          state_d = BS_T3;
      default:        state_d = BS_FREE;
    endcase
    addr_d  = accept ? req_addr  : cur_addr_q;
    write_d = accept ? req_write : cur_write_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= BS_FREE;
      cur_addr_q  <= '0;
      cur_write_q <= 1'b0;
      cur_area_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_addr_q  <= req_addr;
        cur_write_q <= req_write;
        cur_area_q  <= req_area;
      end
    end
  end
endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           state_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              write_d,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_oe,
  output logic              bus_ack
);
  logic data_phase;

  assign data_phase = (state_d == BS_T2) || (state_d == BS_T3);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      bus_oe   <= 1'b0;
      bus_ack  <= 1'b0;
    end else begin
      bus_addr <= addr_d;
      bus_rd   <= !write_d && data_phase;
      bus_wr   <= write_d && (state_d == BS_T2);
      bus_oe   <= write_d && data_phase;
      bus_ack  <= (state_d == BS_T3);
    end
  end
endmodule

// File: rtl/xbus_idle_seq.sv
module xbus_idle_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic              cfg_rr_gap,
  input  logic              cfg_wr_gap,
  input  logic              mode_adv,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_oe,
  output logic [2:0]        bus_state,
  output logic              bus_ack
);
  bus_st_e           state_q;
  bus_st_e           state_d;
  logic              hist_valid;
  logic              cur_write_q;
  logic [AREA_W-1:0] cur_area_q;
  logic [ADDR_W-1:0] addr_d;
  logic              write_d;
  logic              gap;

  xbus_gap_decider #(.AREA_W(AREA_W)) gap_i (
    .prev_valid (hist_valid),
    .prev_write (cur_write_q),
    .prev_area  (cur_area_q),
    .next_write (req_write),
    .next_area  (req_area),
    .rr_en      (cfg_rr_gap),
    .wr_en      (cfg_wr_gap),
    .adv_mode   (mode_adv),
    .gap        (gap)
  );

  xbus_cycle_fsm #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_area    (req_area),
    .gap         (gap),
    .state_q     (state_q),
    .state_d     (state_d),
    .hist_valid  (hist_valid),
    .cur_write_q (cur_write_q),
    .cur_area_q  (cur_area_q),
    .addr_d      (addr_d),
    .write_d     (write_d)
  );

  xbus_pin_drive #(.ADDR_W(ADDR_W)) pins_i (
    .clk      (clk),
    .rst      (rst),
    .state_d  (state_d),
    .addr_d   (addr_d),
    .write_d  (write_d),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_oe   (bus_oe),
    .bus_ack  (bus_ack)
  );

  assign bus_state = state_q;
endmodule

// File: rtl/xbus_idle_seq_chk.sv
module xbus_idle_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] bus_state,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       bus_oe,
  input logic       bus_ack
);
  AST_ACK_ONLY_T3: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> bus_state == 3'd4);  // R1
  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd2 |=> bus_state == 3'd3);  // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && (bus_wr || bus_oe)));  // R2
  AST_TI_THEN_T1: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd1 |=> bus_state == 3'd2);  // R3
  AST_TI_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd1 |-> $past(bus_rd) && $past(bus_state) == 3'd4);  // R7
  AST_TI_QUIET: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd1 |-> !bus_rd && !bus_wr && !bus_oe && !bus_ack);  // R8
  AST_FREE_NO_TI: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd0 |=> bus_state != 3'd1);  // R9
endmodule

bind xbus_idle_seq xbus_idle_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_state (bus_state),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_oe    (bus_oe),
  .bus_ack   (bus_ack)
);

// File: tb/xbus_idle_seq_tb.sv
module xbus_idle_seq_tb_top;
  localparam int ADDR_W = 16;
  localparam int AREA_W = 3;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, cfg_rr_gap, cfg_wr_gap, mode_adv;
  logic [ADDR_W-1:0] req_addr;
  logic [AREA_W-1:0] req_area;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_rd, bus_wr, bus_oe, bus_ack;
  logic [2:0] bus_state;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  xbus_idle_seq #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_area(req_area), .cfg_rr_gap(cfg_rr_gap),
    .cfg_wr_gap(cfg_wr_gap), .mode_adv(mode_adv), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_oe(bus_oe),
    .bus_state(bus_state), .bus_ack(bus_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R1: actual hung expected done");
    finish_run();
  end

  // state codes (R11): free=0, TI=1, T1=2, T2=3, T3=4
  initial begin
    int est [0:9];
    logic [ADDR_W-1:0] eaddr [0:9];
    logic ew [0:9];
    rst = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_area = '0;
    cfg_rr_gap = 1'b0; cfg_wr_gap = 1'b0; mode_adv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 state", 32'(bus_state), 0);
    chk("R10 strobes", {bus_rd, bus_wr, bus_oe, bus_ack}, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 idle after reset", 32'(bus_state), 0);
    chk("R10 strobes after reset", {bus_rd, bus_wr, bus_oe, bus_ack}, 0);

    for (int b2b = 0; b2b < 2; b2b++)
    for (int aw = 0; aw < 2; aw++)
    for (int bw = 0; bw < 2; bw++)
    for (int same = 0; same < 2; same++)
    for (int crr = 0; crr < 2; crr++)
    for (int cwr = 0; cwr < 2; cwr++)
    for (int md = 0; md < 2; md++) begin
      logic gapx;
      int n, bidx;
      string stag;
      logic [ADDR_W-1:0] a_addr, b_addr;
      logic [AREA_W-1:0] a_area, b_area;
      a_addr = ADDR_W'(16'h1000 + 16'(b2b*64 + aw*32 + bw*16 + same*8 + crr*4 + cwr*2 + md));
      b_addr = ~a_addr;
      a_area = 3'd1;
      b_area = (same != 0) ? 3'd1 : 3'd2;
      gapx = (b2b != 0) && (aw == 0) &&
             (((bw == 0) && (crr != 0) && (md != 0) && (same == 0)) ||
              ((bw != 0) && (cwr != 0)));
      if (gapx) stag = (bw != 0) ? "R6" : "R3";
      else if (b2b == 0) stag = "R9";
      else if (aw != 0) stag = "R7";
      else if (bw != 0) stag = "R6";
      else if (same != 0) stag = "R4";
      else stag = "R5";
      // build the expected sequence
      n = 0;
      for (int s = 2; s <= 4; s++) begin est[n] = s; eaddr[n] = a_addr; ew[n] = aw[0]; n++; end
      if (b2b != 0) bidx = 2;
      else begin
        bidx = 3;
        est[n] = 0; eaddr[n] = a_addr; ew[n] = aw[0]; n++;
      end
      if (gapx) begin est[n] = 1; eaddr[n] = b_addr; ew[n] = bw[0]; n++; end
      for (int s = 2; s <= 4; s++) begin est[n] = s; eaddr[n] = b_addr; ew[n] = bw[0]; n++; end
      est[n] = 0; eaddr[n] = b_addr; ew[n] = bw[0]; n++;

      cfg_rr_gap = crr[0]; cfg_wr_gap = cwr[0]; mode_adv = md[0];
      req_valid = 1'b1; req_write = aw[0]; req_addr = a_addr; req_area = a_area;
      for (int k = 0; k < n; k++) begin
        logic xrd, xwr, xoe, xack;
        @(posedge clk); @(negedge clk);
        xrd  = !ew[k] && (est[k] == 3 || est[k] == 4);
        xwr  = ew[k] && (est[k] == 3);
        xoe  = ew[k] && (est[k] == 3 || est[k] == 4);
        xack = (est[k] == 4);
        chk({stag, " state"}, 32'(bus_state), 32'(est[k]));
        chk((k == 1 || k == 2) ? "R12 addr" : ((est[k] == 1) ? "R8 addr" : "R1 addr"),
            32'(bus_addr), 32'(eaddr[k]));
        chk((est[k] == 1) ? "R8 rd" : "R2 rd", 32'(bus_rd), 32'(xrd));
        chk((est[k] == 1) ? "R8 wr" : "R2 wr", 32'(bus_wr), 32'(xwr));
        chk((est[k] == 1) ? "R8 oe" : "R2 oe", 32'(bus_oe), 32'(xoe));
        chk("R1 ack", 32'(bus_ack), 32'(xack));
        if (k == bidx) begin
          req_valid = 1'b1; req_write = bw[0]; req_addr = b_addr; req_area = b_area;
        end else if (k < 2) begin
          // R12: stray request during T1/T2 must be ignored
          req_valid = 1'b1; req_write = ~aw[0]; req_addr = 16'hBEEF; req_area = 3'd7;
        end else begin
          req_valid = 1'b0;
        end
      end
      req_valid = 1'b0;
    end
    finish_run();
  end
endmodule